// File: doc/BRIEF.md
# Watchdog Timer Peripheral

A register-mapped watchdog that counts a 16-bit value down towards zero and, if software fails to refresh it in time, raises a one-cycle system reset request, a sticky interrupt, or both. The counting rate comes from the core clock through two stages: an 8-bit programmable divide (value plus one), then a divide by 16, 32, 64 or 128 chosen by a 2-bit field.

Software programs a reload value and a starting count, sets the enable and the wanted expiry actions in the control register, then refreshes the count register periodically. Clearing the enable bit freezes the count and keeps the reload value intact, so the timer can be stopped and resumed without reprogramming.

Top module: `wdt_periph`

## Requirements
- R1: After reset the control register reads 0x8021, the reload register reads 0x8000, the count register reads 0x8000, and both rst_req_o and irq_o are low.
- R2: Byte address 0x0 selects control, 0x4 selects reload, 0x8 selects the live count; a read of any other address returns zero.
- R3: Control fields are: bit 0 reset enable, bit 1 interrupt flag (read) / clear (write 1), bit 2 interrupt enable, bits [4:3] divider select (00 /16, 01 /32, 10 /64, 11 /128), bit 5 timer enable, bits [15:8] prescale P. While enabled, the counter steps once every (P+1) x divider clock cycles, the first step that many cycles after the enabling write.
- R4: Each step decrements the count by one; reading address 0x8 returns the current count.
- R5: A step that finds the count at zero is an expiry: the count is loaded from the reload register.
- R6: On an expiry with reset enabled, rst_req_o is high for exactly one cycle, in the cycle after the expiring step; it never pulses otherwise.
- R7: On an expiry with interrupt enabled, irq_o rises in the cycle after the step and stays high until control is written with bit 1 set; control bit 1 reads the flag.
- R8: A write to the count register loads the written value at once and takes priority over a coincident step (keep-alive).
- R9: With the enable bit clear the count holds, the reload value is kept and no expiry occurs.
- R10: With both enables set, one expiry raises rst_req_o and irq_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address of the register |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Sticky expiry interrupt |

## Verification
The assertions assume a write strobe lasts one cycle and that the step period is never shorter than 16 cycles, which the divider guarantees, so two expiries can never fall on adjacent cycles. The stimulus always disables the timer before changing prescale or divider, so each timed run starts from a cleared prescaler and its expiry cycle can be predicted exactly from the programmed count, prescale and divider. Keep-alive writes are spaced shorter than the expiry interval so any reset pulse during them is a defect.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 16;
  localparam int PRE_W      = 8;
  localparam int SEL_W      = 2;
  localparam int BASE_LOG2  = 4;

  localparam int OFF_CTRL   = 'h0;
  localparam int OFF_RELOAD = 'h4;
  localparam int OFF_COUNT  = 'h8;

  // bit positions software depends on
  localparam int B_RST_EN   = 0;
  localparam int B_IRQ_FLAG = 1;
  localparam int B_IRQ_EN   = 2;
  localparam int B_SEL_LO   = 3;
  localparam int B_EN       = 5;
  localparam int B_PRE_LO   = 8;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{presc: 8'h80, en: 1'b1, sel: 2'b00,
                                 irq_en: 1'b0, rst_en: 1'b1};
  localparam logic [CNT_W-1:0] RELOAD_RST = 16'h8000;
  localparam logic [CNT_W-1:0] COUNT_RST  = 16'h8000;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PRE_W     = 8,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] div_last;
  logic             pre_tick;

  always_comb begin
    span     = (DIV_W+1)'(1) << (BASE_LOG2 + int'(sel_i));
    div_last = DIV_W'(span - 1'b1);
    pre_tick = run_i && (pre_q == presc_i);
    tick_o   = pre_tick && (div_q == div_last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_tick ? '0 : pre_q + 1'b1;
      if (pre_tick) div_q <= (div_q == div_last) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // a keep-alive write wins over a coincident step
  assign expire_o = tick_i && !load_i && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_RST;
    else if (load_i)   cnt_q <= load_val_i;
    else if (expire_o) cnt_q <= reload_i;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_periph.sv
module wdt_periph
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt;
  logic             irq_q, rst_q;
  logic             ctrl_wr, reload_wr, cnt_wr;
  logic             tick, expire;

  assign ctrl_wr   = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign reload_wr = we_i && (addr_i == ADDR_W'(OFF_RELOAD));
  assign cnt_wr    = we_i && (addr_i == ADDR_W'(OFF_COUNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= RELOAD_RST;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.presc  <= wdata_i[B_PRE_LO +: PRE_W];
        ctrl_q.en     <= wdata_i[B_EN];
        ctrl_q.sel    <= wdata_i[B_SEL_LO +: SEL_W];
        ctrl_q.irq_en <= wdata_i[B_IRQ_EN];
        ctrl_q.rst_en <= wdata_i[B_RST_EN];
      end
      if (reload_wr) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  wdt_prescale #(
    .PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl_q.en),
    .presc_i(ctrl_q.presc), .sel_i(ctrl_q.sel), .tick_o(tick)
  );

  wdt_counter #(
    .CNT_W(CNT_W), .CNT_RST(COUNT_RST)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_wr),
    .load_val_i(wdata_i[CNT_W-1:0]), .tick_i(tick),
    .reload_i(reload_q), .cnt_o(cnt), .expire_o(expire)
  );

  // set beats clear when both land in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= expire && ctrl_q.rst_en;
      if (expire && ctrl_q.irq_en)             irq_q <= 1'b1;
      else if (ctrl_wr && wdata_i[B_IRQ_FLAG]) irq_q <= 1'b0;
    end
  end

  assign rst_req_o = rst_q;
  assign irq_o     = irq_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CTRL)) begin
      rdata_o[B_PRE_LO +: PRE_W] = ctrl_q.presc;
      rdata_o[B_EN]              = ctrl_q.en;
      rdata_o[B_SEL_LO +: SEL_W] = ctrl_q.sel;
      rdata_o[B_IRQ_EN]          = ctrl_q.irq_en;
      rdata_o[B_IRQ_FLAG]        = irq_q;
      rdata_o[B_RST_EN]          = ctrl_q.rst_en;
    end else if (addr_i == ADDR_W'(OFF_RELOAD)) begin
      rdata_o[CNT_W-1:0] = reload_q;
    end else if (addr_i == ADDR_W'(OFF_COUNT)) begin
      rdata_o[CNT_W-1:0] = cnt;
    end
  end
endmodule

// File: rtl/wdt_periph_chk.sv
module wdt_periph_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             rst_en_i,
  input logic             cnt_wr_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             rst_req_o,
  input logic             irq_o
);
  // R6
  rst_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R6
  rst_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(rst_en_i) && $past(en_i));
  // R9
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr_i) |=> $stable(cnt_i));
  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  // R4
  step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr_i && cnt_i != '0) |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) - 1'b1));
endmodule

bind wdt_periph wdt_periph_chk #(.CNT_W(wdt_pkg::CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctrl_q.en), .rst_en_i(ctrl_q.rst_en),
  .cnt_wr_i(cnt_wr), .clr_i(ctrl_wr && wdata_i[1]), .cnt_i(cnt),
  .rst_req_o(rst_req_o), .irq_o(irq_o)
);

// File: tb/wdt_periph_tb.sv
module wdt_periph_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, irq;

  int total = 0, bad = 0, cyc = 0, c0 = 0;
  bit done = 1'b0;
  int exp_q[$];

  wdt_periph u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    c0 = cyc;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: each reset pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6: actual=pulse@%0d expected=no pulse", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          bad++;
          $display("FAIL R6: actual=pulse@%0d expected=pulse@%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 decode
    rd_chk("R1 ctrl", 4'h0, 32'h8021);
    rd_chk("R1 reload", 4'h4, 32'h8000);
    rd_chk("R1 count", 4'h8, 32'h8000);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd_chk("R2 unused", 4'hC, 0);

    // R9 stop keeps reload and freezes count
    wr(4'h0, 32'h0);
    rd(4'h8, a);
    wait_to(c0 + 300);
    rd(4'h8, b);
    chk("R9 count frozen", b, a);
    rd_chk("R9 reload kept", 4'h4, 32'h8000);

    // R3/R4/R5/R6: prescale 1, /16 -> 32 cycles per step, count 3
    wr(4'h4, 32'd5);
    wr(4'h8, 32'd3);
    rd_chk("R8 count load", 4'h8, 3);
    wr(4'h0, 32'h0121);
    exp_q.push_back(c0 + 128);
    wait_to(c0 + 31);
    rd_chk("R3 no step early", 4'h8, 3);
    wait_to(c0 + 40);
    rd_chk("R4 decrement", 4'h8, 2);
    wait_to(c0 + 130);
    rd_chk("R5 reload on expiry", 4'h8, 5);
    // R8 keep-alive spaced below the 192-cycle expiry interval
    for (int k = 0; k < 4; k++) begin
      wr(4'h8, 32'd5);
      wait_to(c0 + 100);
    end
    wr(4'h0, 32'h0);
    chk("R8 keep-alive no pulse", exp_q.size(), 0);
    rd_chk("R9 reload after stop", 4'h4, 5);

    // R7 interrupt only, /32, prescale 0
    wr(4'h4, 32'd2);
    wr(4'h8, 32'd1);
    wr(4'h0, 32'h002C);
    wait_to(c0 + 63);
    chk("R7 irq not yet", {31'b0, irq}, 0);
    wait_to(c0 + 64);
    chk("R7 irq set", {31'b0, irq}, 1);
    rd_chk("R5 reload 2", 4'h8, 2);
    rd_chk("R7 flag readback", 4'h0, 32'h002E);
    wr(4'h0, 32'h0006);
    chk("R7 irq cleared", {31'b0, irq}, 0);
    rd_chk("R7 ctrl after clear", 4'h0, 32'h0004);

    // R3 /128 from count 0
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h003C);
    wait_to(c0 + 127);
    chk("R3 /128 not yet", {31'b0, irq}, 0);
    wait_to(c0 + 128);
    chk("R3 /128 expiry", {31'b0, irq}, 1);
    wr(4'h0, 32'h0002);
    chk("R7 clear and stop", {31'b0, irq}, 0);

    // R10 both actions, /64
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h0035);
    exp_q.push_back(c0 + 64);
    wait_to(c0 + 64);
    chk("R10 irq with reset", {31'b0, irq}, 1);
    chk("R10 rst_req with irq", {31'b0, rst_req}, 1);
    wait_to(c0 + 70);
    wr(4'h0, 32'h0002);
    wait_to(c0 + 20);
    chk("R6 all pulses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule